// File: doc/BRIEF.md
# SCL Period Generator for an I2C Master

This block produces the serial clock of an I2C master as an open-drain output. Software loads four count registers: one high count and one low count for standard speed, and another pair for fast speed. A speed field in a control word chooses which pair sets the timing. All times are whole cycles of the reference clock.

When the controller is enabled and a clock run is requested, the block first holds the line released for a start-hold interval. The length of that interval comes from the high count. The block then alternates low and high phases. The low phase begins on the cycle the block pulls the line low. The high phase is counted only after the line is sensed high, so a slave that holds the line low lengthens the low part of the period.

Counts below a floor value are raised to that floor. The count registers accept writes only while the controller is disabled.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, `phase` reads 0 (idle) and `scl_pull_low` is 0.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`: 0 is standard high, 1 is standard low, 2 is fast high, 3 is fast low. The write takes effect only when `enable` is low. A write while `enable` is high leaves the timing unchanged.
- R3: Bits 2:1 of `ctrl_word` pick the speed. Values 2 and 3 select the fast pair; values 0 and 1 select the standard pair. Bit 0 must be 1 for any clock to start. The remaining bits have no effect.
- R4: The start-hold phase (`phase` = 1, line released) lasts the effective high count plus 3 cycles.
- R5: The low phase (`phase` = 2) lasts the effective low count plus 1 cycles. `scl_pull_low` is 1 exactly during this phase.
- R6: After the low phase, `phase` = 3 (line released) holds until `scl_in` is sensed high. The high phase starts on the next cycle.
- R7: The high phase (`phase` = 4) lasts the effective high count plus 8 cycles.
- R8: The effective high count is the larger of the register value and 6. The effective low count is the larger of the register value and 8.
- R9: At the end of a high phase, a new low phase follows if `run` is high and bit 0 of `ctrl_word` is set. Otherwise the block returns to idle. In idle, a new start needs `enable`, `run` and bit 0 all high.
- R10: With `enable` low, `phase` is 0 on the next cycle and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low forces idle and opens the count registers for writing |
| ctrl_word | input | 7 | Control word: bit 0 master, bits 2:1 speed |
| run | input | 1 | Request for continuous clocking |
| wr_en | input | 1 | Count register write strobe |
| wr_sel | input | 2 | Count register select |
| wr_data | input | CW | Count value to write |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | Open-drain drive; 1 pulls SCL low |
| phase | output | 3 | Current phase code (0 idle, 1 hold, 2 low, 3 wait-high, 4 high) |

## Verification
A phase change decided at a clock edge appears on `phase` and `scl_pull_low` right after that edge. A register write or a change of `scl_in` therefore shows on the outputs one cycle later. A phase whose length is N cycles shows its code for exactly N consecutive cycles. The bench sets its inputs between edges and steps a behavioural model on the same edges. It compares `phase` and `scl_pull_low` with the model at every falling edge. It also measures each phase by counting falling edges while the code holds, and compares those lengths with the counts derived from the requirements.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HOLD = 3'd1,
    PH_LOW  = 3'd2,
    PH_WAIT = 3'd3,
    PH_HIGH = 3'd4
  } scl_phase_e;

  localparam int unsigned FLOOR_HIGH = 6;
  localparam int unsigned FLOOR_LOW  = 8;
  localparam int unsigned ADD_HIGH   = 8;
  localparam int unsigned ADD_LOW    = 1;
  localparam int unsigned ADD_HOLD   = 3;

  function automatic int unsigned clamp_floor(int unsigned v, int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  function automatic int unsigned high_cycles(int unsigned h);
    return clamp_floor(h, FLOOR_HIGH) + ADD_HIGH;
  endfunction

  function automatic int unsigned low_cycles(int unsigned l);
    return clamp_floor(l, FLOOR_LOW) + ADD_LOW;
  endfunction

  function automatic int unsigned hold_cycles(int unsigned h);
    return clamp_floor(h, FLOOR_HIGH) + ADD_HOLD;
  endfunction

endpackage

// File: rtl/scl_count_regs.sv
module scl_count_regs #(
  parameter int CW = 16,
  parameter logic [CW-1:0] DEF_SS_HIGH = 190,
  parameter logic [CW-1:0] DEF_SS_LOW  = 250,
  parameter logic [CW-1:0] DEF_FS_HIGH = 40,
  parameter logic [CW-1:0] DEF_FS_LOW  = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ss_high,
  output logic [CW-1:0] ss_low,
  output logic [CW-1:0] fs_high,
  output logic [CW-1:0] fs_low
);
  localparam int NREG = 4;

  logic [CW-1:0] cnt_q [NREG];
  logic          wr_open;

  assign wr_open = wr_en && !enable;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [CW-1:0] RST_VAL = (g == 0) ? DEF_SS_HIGH :
                                        (g == 1) ? DEF_SS_LOW  :
                                        (g == 2) ? DEF_FS_HIGH : DEF_FS_LOW;
    logic hit;
    assign hit = wr_open && (wr_sel == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q[g] <= RST_VAL;
      else if (hit) cnt_q[g] <= wr_data;
    end
  end

  assign ss_high = cnt_q[0];
  assign ss_low  = cnt_q[1];
  assign fs_high = cnt_q[2];
  assign fs_low  = cnt_q[3];
endmodule

// File: rtl/scl_len_sel.sv
module scl_len_sel
  import scl_gen_pkg::*;
#(
  parameter int CW = 16,
  localparam int LW = CW + 1
) (
  input  logic          fast_sel,
  input  logic [CW-1:0] ss_high,
  input  logic [CW-1:0] ss_low,
  input  logic [CW-1:0] fs_high,
  input  logic [CW-1:0] fs_low,
  output logic [LW-1:0] hold_len,
  output logic [LW-1:0] low_len,
  output logic [LW-1:0] high_len
);
  logic [CW-1:0] h_pick, l_pick;

  always_comb begin
    h_pick   = fast_sel ? fs_high : ss_high;
    l_pick   = fast_sel ? fs_low  : ss_low;
    hold_len = LW'(hold_cycles(32'(h_pick)));
    low_len  = LW'(low_cycles(32'(l_pick)));
    high_len = LW'(high_cycles(32'(h_pick)));
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          go,
  input  logic          scl_in,
  input  logic [LW-1:0] hold_len,
  input  logic [LW-1:0] low_len,
  input  logic [LW-1:0] high_len,
  output scl_phase_e    phase_q,
  output logic          cnt_done
);
  logic [LW-1:0] cnt_q;
  localparam logic [LW-1:0] ONE = LW'(1);

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!enable) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (go) begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_len - ONE;
        end
        PH_HOLD: if (cnt_done) begin
          phase_q <= PH_LOW;
          cnt_q   <= low_len - ONE;
        end else cnt_q <= cnt_q - ONE;
        PH_LOW: if (cnt_done) phase_q <= PH_WAIT;
                else          cnt_q   <= cnt_q - ONE;
        PH_WAIT: if (scl_in) begin
          phase_q <= PH_HIGH;
          cnt_q   <= high_len - ONE;
        end
        PH_HIGH: if (cnt_done) begin
          if (go) begin
            phase_q <= PH_LOW;
            cnt_q   <= low_len - ONE;
          end else phase_q <= PH_IDLE;
        end else cnt_q <= cnt_q - ONE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CW = 16,
  parameter logic [CW-1:0] DEF_SS_HIGH = 190,
  parameter logic [CW-1:0] DEF_SS_LOW  = 250,
  parameter logic [CW-1:0] DEF_FS_HIGH = 40,
  parameter logic [CW-1:0] DEF_FS_LOW  = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [6:0]    ctrl_word,
  input  logic          run,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic [2:0]    phase
);
  localparam int LW = CW + 1;

  logic [CW-1:0] ss_high, ss_low, fs_high, fs_low;
  logic [LW-1:0] hold_len, low_len, high_len;
  logic          master_on, fast_sel, go, cnt_done;
  logic          unused_ctrl;
  scl_phase_e    phase_q;

  assign master_on   = ctrl_word[0];
  assign fast_sel    = ctrl_word[2];
  assign go          = run && master_on;
  assign unused_ctrl = ^{ctrl_word[6:3], ctrl_word[1], cnt_done};

  scl_count_regs #(
    .CW(CW), .DEF_SS_HIGH(DEF_SS_HIGH), .DEF_SS_LOW(DEF_SS_LOW),
    .DEF_FS_HIGH(DEF_FS_HIGH), .DEF_FS_LOW(DEF_FS_LOW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .ss_high(ss_high), .ss_low(ss_low), .fs_high(fs_high), .fs_low(fs_low)
  );

  scl_len_sel #(.CW(CW)) u_len (
    .fast_sel(fast_sel), .ss_high(ss_high), .ss_low(ss_low),
    .fs_high(fs_high), .fs_low(fs_low),
    .hold_len(hold_len), .low_len(low_len), .high_len(high_len)
  );

  scl_phase_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .go(go), .scl_in(scl_in),
    .hold_len(hold_len), .low_len(low_len), .high_len(high_len),
    .phase_q(phase_q), .cnt_done(cnt_done)
  );

  assign phase        = phase_q;
  assign scl_pull_low = (phase_q == PH_LOW);
endmodule

// File: rtl/scl_period_chk.sv
module scl_period_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          go,
  input logic          scl_in,
  input logic          scl_pull_low,
  input logic [2:0]    phase,
  input logic [CW-1:0] ss_high,
  input logic [CW-1:0] ss_low,
  input logic [CW-1:0] fs_high,
  input logic [CW-1:0] fs_low
);
  // R10: disabling forces idle one cycle later
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == 3'd0));

  // R2: count registers are frozen while enabled
  assert_regs_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(ss_high) && $stable(ss_low) && $stable(fs_high) && $stable(fs_low)));

  // R6: the wait phase holds while the line is sensed low
  assert_wait_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && !scl_in && enable) |=> (phase == 3'd3));

  // R5: the line is pulled low only after a hold or high phase
  assert_low_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> ($past(phase) == 3'd1 || $past(phase) == 3'd4));

  // R9: idle stays idle without a start request
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !(enable && go)) |=> (phase == 3'd0));
endmodule

bind scl_period_gen scl_period_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .go(go), .scl_in(scl_in),
  .scl_pull_low(scl_pull_low), .phase(phase),
  .ss_high(ss_high), .ss_low(ss_low), .fs_high(fs_high), .fs_low(fs_low)
);

// File: tb/scl_period_gen_tb.sv
`timescale 1ns/1ps
module scl_period_gen_tb;
  localparam int CW = 16;
  localparam int D_SH = 190, D_SL = 250, D_FH = 40, D_FL = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [6:0] ctrl_word = '0;
  logic run = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic stretch = 1'b0;
  logic scl_in;
  logic scl_pull_low;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign scl_in = !scl_pull_low && !stretch;

  scl_period_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
    .run(run), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low), .phase(phase)
  );

  // Behavioural reference: elapsed-cycle counting per phase
  int m_ph = 0, m_el = 0, m_len = 0;
  int m_reg [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_len = 0;
      m_reg[0] = D_SH; m_reg[1] = D_SL; m_reg[2] = D_FH; m_reg[3] = D_FL;
    end else begin
      bit go_m, line_hi;
      int h, l;
      go_m    = run && ctrl_word[0];
      line_hi = (m_ph != 2) && !stretch;
      h = (ctrl_word[2:1] >= 2) ? m_reg[2] : m_reg[0];
      l = (ctrl_word[2:1] >= 2) ? m_reg[3] : m_reg[1];
      if (h < 6) h = 6;
      if (l < 8) l = 8;
      if (!enable) m_ph = 0;
      else if (m_ph == 0) begin
        if (go_m) begin m_ph = 1; m_len = h + 3; m_el = 0; end
      end else if (m_ph == 3) begin
        if (line_hi) begin m_ph = 4; m_len = h + 8; m_el = 0; end
      end else begin
        m_el++;
        if (m_el == m_len) begin
          if (m_ph == 1)      begin m_ph = 2; m_len = l + 1; m_el = 0; end
          else if (m_ph == 2) m_ph = 3;
          else if (go_m)      begin m_ph = 2; m_len = l + 1; m_el = 0; end
          else                m_ph = 0;
        end
      end
      if (wr_en && !enable) m_reg[wr_sel] = int'(wr_data);
    end
  end

  function automatic string req_of(int p);
    case (p)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(phase) != m_ph || scl_pull_low != (m_ph == 2)) begin
        errors++;
        $display("FAIL %s model: phase=%0d pull=%0b expected phase=%0d pull=%0b",
                 req_of(m_ph), phase, scl_pull_low, m_ph, (m_ph == 2));
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = CW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int ph, output int len);
    while (int'(phase) != ph) @(negedge clk);
    len = 0;
    while (int'(phase) == ph) begin len++; @(negedge clk); end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phase", int'(phase), 0);
    check("R1 pull", int'(scl_pull_low), 0);

    // R2 writes while disabled; fast values below the floors (R8)
    wr(0, 10); wr(1, 12); wr(2, 3); wr(3, 2);

    // standard speed, bit 4 set to show it is ignored (R3)
    ctrl_word = 7'b0010011;
    enable = 1'b1; run = 1'b1;
    wr(0, 50);                      // R2: ignored while enabled
    measure(1, n); check("R4 hold std", n, 13);
    measure(2, n); check("R5 low std", n, 13);
    measure(3, n); check("R6 wait", n, 1);
    measure(4, n); check("R7 high std (R2 write ignored)", n, 18);
    check("R9 next low", int'(phase), 2);

    // R6 stretching
    stretch = 1'b1;
    while (phase != 3'd3) @(negedge clk);
    n = 1;
    repeat (4) begin @(negedge clk); if (phase == 3'd3) n++; end
    stretch = 1'b0;
    @(negedge clk);
    check("R6 stretched wait", n, 5);
    check("R6 high after release", int'(phase), 4);

    // R9 stop at end of high
    run = 1'b0;
    while (phase == 3'd4) @(negedge clk);
    check("R9 idle after high", int'(phase), 0);
    repeat (5) @(negedge clk);
    check("R9 stays idle", int'(phase), 0);

    // fast speed with clamped counts (R3, R8)
    enable = 1'b0; @(negedge clk);
    ctrl_word = 7'b0000101;
    enable = 1'b1; run = 1'b1;
    measure(1, n); check("R8 hold fast clamp", n, 9);
    measure(2, n); check("R8 low fast clamp", n, 9);
    measure(4, n); check("R8 high fast clamp", n, 14);

    // R10 disable during low
    while (phase != 3'd2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R10 idle", int'(phase), 0);
    check("R10 released", int'(scl_pull_low), 0);

    // R3 speed value 3 selects fast
    ctrl_word = 7'b0000111;
    enable = 1'b1;
    measure(1, n); check("R3 speed3 hold", n, 9);
    enable = 1'b0; @(negedge clk);

    // R3 master bit clear: no clock
    ctrl_word = 7'b0000100;
    enable = 1'b1;
    n = 0;
    repeat (20) begin @(negedge clk); if (phase != 3'd0) n++; end
    check("R3 no master no clock", n, 0);
    enable = 1'b0; @(negedge clk);

    // R2 write while disabled takes effect
    wr(0, 20);
    ctrl_word = 7'b0000011;
    enable = 1'b1;
    measure(1, n); check("R2 new std hold", n, 23);
    enable = 1'b0; run = 1'b0;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule